// File: doc/BRIEF.md
# Modulo Address Pointer Unit

This block produces data-memory word addresses for two pointers that work side by side, an X side and a Y side, as used by paired load and store operations in a signal-processing datapath. Each side owns two pointer registers and one index register. On a transfer, the chosen pointer is driven out as the memory address. The pointer is then either kept, advanced by two bytes, or advanced by the side's index, and the result is written back into the pointer.

A single modulo register holds a start and an end address for a circular buffer. A separate wrap enable for each side decides whether that side honours the buffer. When wrapping is on and the pointer equals the end address before it is updated, the low half of the pointer is replaced with the start address. The high half is left unchanged. Only address bits above bit 0 take part, so the buffer can reach the full range of the low half, which is 64 kbytes in the default configuration.

Top module: `modaddr_unit`

## Requirements
- R1: After reset, all pointer and index registers, the modulo register, both wrap enables, both address outputs, both next-pointer outputs and both valid flags are zero.
- R2: A register load with `reg_we` high writes `reg_wdata` on the next clock edge. The load goes to the side given by `reg_sel[2]` (0 = X, 1 = Y) and to the target given by `reg_sel[1:0]` (0 = pointer 0, 1 = pointer 1, 2 = index, 3 = nothing). No other register changes.
- R3: A transfer requested in one cycle shows its results after the next clock edge. At that point the side's valid output is 1, and its address output equals bits LOW_W-1..1 of the selected pointer as it was before the update.
- R4: The update mode codes are 0 = keep, 1 = add 2, 2 = add the side's index and 3 = keep. When no wrap occurs, the next-pointer output and the selected pointer both take the updated value, computed at full pointer width.
- R5: A wrap happens when the side's wrap enable is 1, the mode is 1 or 2, and bits LOW_W-1..1 of the old pointer equal those bits of the end address. On a wrap, the low LOW_W bits of the new pointer are the start address with bit 0 forced to 0, and the upper bits keep their old value.
- R6: In modes 0 and 3, no wrap occurs even when the pointer matches the end address.
- R7: The X side checks only `cfg_wrap_x` and the Y side checks only `cfg_wrap_y`. With wrapping disabled on a side, a match on that side is treated as an ordinary update.
- R8: Bit 0 of the start and end fields has no effect on the compare or on the wrap value.
- R9: `mod_we` loads the end address from the upper LOW_W bits of `mod_wdata` and the start address from the lower LOW_W bits. `cfg_we` loads both wrap enables.
- R10: X and Y transfers in the same cycle are computed independently against the same start and end pair, and both write back on that edge.
- R11: A normal update carries out of bit LOW_W-1 into the upper pointer bits.
- R12: The valid output of a side is 0 after any cycle in which that side made no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Pointer or index register load strobe |
| reg_sel | input | 3 | Side (bit 2) and target (bits 1:0) of the load |
| reg_wdata | input | PTR_W | Load data |
| mod_we | input | 1 | Modulo register load strobe |
| mod_wdata | input | 2*LOW_W | End address (upper half) and start address (lower half) |
| cfg_we | input | 1 | Wrap enable load strobe |
| cfg_wrap_x | input | 1 | Wrap enable for X |
| cfg_wrap_y | input | 1 | Wrap enable for Y |
| x_go | input | 1 | X transfer request |
| x_sel | input | 1 | X pointer select |
| x_mode | input | 2 | X update mode |
| y_go | input | 1 | Y transfer request |
| y_sel | input | 1 | Y pointer select |
| y_mode | input | 2 | Y update mode |
| x_addr | output | LOW_W-1 | X word address |
| x_next | output | PTR_W | X written-back pointer |
| x_valid | output | 1 | X result valid |
| y_addr | output | LOW_W-1 | Y word address |
| y_next | output | PTR_W | Y written-back pointer |
| y_valid | output | 1 | Y result valid |

## Verification
The bench builds the unit with PTR_W=12 and LOW_W=8. With these values, every one of the 256 low-half pointer values can be swept on both sides, for each wrap enable setting and each of the four mode codes, against a start and end pair whose bit 0 is set. The sweep puts a distinct pattern in the upper four bits, so that their preservation on a wrap and the carry into them on an ordinary update are both visible. Directed cases then cover simultaneous X and Y wraps, enables that differ between the sides, and a reload of the modulo register.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_STEP  = 2'd1,
    UPD_INDEX = 2'd2,
    UPD_RSVD  = 2'd3
  } upd_mode_e;

  localparam int STEP_BYTES = 2;
endpackage

// File: rtl/modaddr_side.sv
module modaddr_side
  import modaddr_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int LOW_W = 16
) (
  input  logic [PTR_W-1:0] cur_i,
  input  logic [PTR_W-1:0] idx_i,
  input  upd_mode_e        mode_i,
  input  logic             wrap_en_i,
  input  logic [LOW_W-1:0] ms_i,
  input  logic [LOW_W-1:0] me_i,
  output logic [PTR_W-1:0] next_o,
  output logic             wrap_o
);
  localparam int HI_W = PTR_W - LOW_W;
  localparam logic [LOW_W-1:0] LSB_MASK = ~LOW_W'(1);

  logic [PTR_W-1:0] upd;
  logic             updating;
  logic             hit;

  always_comb begin
    unique case (mode_i)
      UPD_STEP:  upd = cur_i + PTR_W'(STEP_BYTES);
      UPD_INDEX: upd = cur_i + idx_i;
      default:   upd = cur_i;
    endcase
    updating = (mode_i == UPD_STEP) || (mode_i == UPD_INDEX);
    // compare ignores bit 0 on both operands
    hit      = ((cur_i[LOW_W-1:0] ^ me_i) & LSB_MASK) == '0;
    wrap_o   = wrap_en_i && updating && hit;
    next_o   = wrap_o ? {cur_i[PTR_W-1:LOW_W], ms_i & LSB_MASK} : upd;
  end

  initial begin
    a_r5_width_split: assert (HI_W > 0);
  end
endmodule

// File: rtl/modaddr_bank.sv
module modaddr_bank
  import modaddr_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int LOW_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [PTR_W-1:0] wr_data,
  input  logic             go_i,
  input  logic             sel_i,
  input  upd_mode_e        mode_i,
  input  logic             wrap_en_i,
  input  logic [LOW_W-1:0] ms_i,
  input  logic [LOW_W-1:0] me_i,
  output logic [LOW_W-2:0] addr_o,
  output logic [PTR_W-1:0] next_o,
  output logic             valid_o
);
  logic [PTR_W-1:0] ptr_q [2];
  logic [PTR_W-1:0] idx_q;
  logic [PTR_W-1:0] cur;
  logic [PTR_W-1:0] nxt;
  logic             wrap;

  assign cur = ptr_q[sel_i];

  modaddr_side #(.PTR_W(PTR_W), .LOW_W(LOW_W)) u_side (
    .cur_i    (cur),
    .idx_i    (idx_q),
    .mode_i   (mode_i),
    .wrap_en_i(wrap_en_i),
    .ms_i     (ms_i),
    .me_i     (me_i),
    .next_o   (nxt),
    .wrap_o   (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q[0] <= '0;
      ptr_q[1] <= '0;
      idx_q    <= '0;
      addr_o   <= '0;
      next_o   <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= go_i;
      if (go_i) begin
        addr_o       <= cur[LOW_W-1:1];
        next_o       <= nxt;
        ptr_q[sel_i] <= nxt;
      end
      // an explicit load overrides a write-back in the same cycle
      if (wr_en) begin
        case (wr_sel)
          2'd0:    ptr_q[0] <= wr_data;
          2'd1:    ptr_q[1] <= wr_data;
          2'd2:    idx_q    <= wr_data;
          default: ;
        endcase
      end
    end
  end

  a_r3_addr_before_update: assert property (@(posedge clk) disable iff (rst)
    go_i |=> valid_o && addr_o == $past(cur[LOW_W-1:1]));

  a_r12_idle_not_valid: assert property (@(posedge clk) disable iff (rst)
    !go_i |=> !valid_o);

  a_r6_hold_keeps_pointer: assert property (@(posedge clk) disable iff (rst)
    go_i && (mode_i == UPD_HOLD || mode_i == UPD_RSVD) |=> next_o == $past(cur));

  a_r4_step_by_two: assert property (@(posedge clk) disable iff (rst)
    go_i && mode_i == UPD_STEP && !wrap |=> next_o == $past(cur) + PTR_W'(STEP_BYTES));

  a_r5_wrap_keeps_high: assert property (@(posedge clk) disable iff (rst)
    go_i && wrap |=> next_o[PTR_W-1:LOW_W] == $past(cur[PTR_W-1:LOW_W]) && !next_o[0]);
endmodule

// File: rtl/modaddr_unit.sv
module modaddr_unit
  import modaddr_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int LOW_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [PTR_W-1:0]   reg_wdata,
  input  logic               mod_we,
  input  logic [2*LOW_W-1:0] mod_wdata,
  input  logic               cfg_we,
  input  logic               cfg_wrap_x,
  input  logic               cfg_wrap_y,
  input  logic               x_go,
  input  logic               x_sel,
  input  logic [1:0]         x_mode,
  input  logic               y_go,
  input  logic               y_sel,
  input  logic [1:0]         y_mode,
  output logic [LOW_W-2:0]   x_addr,
  output logic [PTR_W-1:0]   x_next,
  output logic               x_valid,
  output logic [LOW_W-2:0]   y_addr,
  output logic [PTR_W-1:0]   y_next,
  output logic               y_valid
);
  localparam int SIDES = 2;

  logic [LOW_W-1:0] ms_q, me_q;
  logic [SIDES-1:0] wrap_en_q;

  logic [SIDES-1:0]            go_s, sel_s, valid_s;
  logic [SIDES-1:0][1:0]       mode_s;
  logic [SIDES-1:0][LOW_W-2:0] addr_s;
  logic [SIDES-1:0][PTR_W-1:0] next_s;

  assign go_s   = {y_go, x_go};
  assign sel_s  = {y_sel, x_sel};
  assign mode_s = {y_mode, x_mode};

  always_ff @(posedge clk) begin
    if (rst) begin
      ms_q      <= '0;
      me_q      <= '0;
      wrap_en_q <= '0;
    end else begin
      if (mod_we) begin
        me_q <= mod_wdata[2*LOW_W-1:LOW_W];
        ms_q <= mod_wdata[LOW_W-1:0];
      end
      if (cfg_we) wrap_en_q <= {cfg_wrap_y, cfg_wrap_x};
    end
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    modaddr_bank #(.PTR_W(PTR_W), .LOW_W(LOW_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (reg_we && (reg_sel[2] == 1'(s))),
      .wr_sel   (reg_sel[1:0]),
      .wr_data  (reg_wdata),
      .go_i     (go_s[s]),
      .sel_i    (sel_s[s]),
      .mode_i   (upd_mode_e'(mode_s[s])),
      .wrap_en_i(wrap_en_q[s]),
      .ms_i     (ms_q),
      .me_i     (me_q),
      .addr_o   (addr_s[s]),
      .next_o   (next_s[s]),
      .valid_o  (valid_s[s])
    );
  end

  assign x_addr  = addr_s[0];
  assign x_next  = next_s[0];
  assign x_valid = valid_s[0];
  assign y_addr  = addr_s[1];
  assign y_next  = next_s[1];
  assign y_valid = valid_s[1];

  a_r9_modulo_load: assert property (@(posedge clk) disable iff (rst)
    mod_we |=> {me_q, ms_q} == $past(mod_wdata));

  a_r9_enable_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(wrap_en_q));
endmodule

// File: tb/modaddr_unit_test.sv
module modaddr_unit_test;
  localparam int PW = 12;
  localparam int LW = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 0, mod_we = 0, cfg_we = 0, cfg_wrap_x = 0, cfg_wrap_y = 0;
  logic [2:0] reg_sel = '0;
  logic [PW-1:0] reg_wdata = '0;
  logic [2*LW-1:0] mod_wdata = '0;
  logic x_go = 0, x_sel = 0, y_go = 0, y_sel = 0;
  logic [1:0] x_mode = '0, y_mode = '0;
  logic [LW-2:0] x_addr, y_addr;
  logic [PW-1:0] x_next, y_next;
  logic x_valid, y_valid;

  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modaddr_unit #(.PTR_W(PW), .LOW_W(LW)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mod_we(mod_we), .mod_wdata(mod_wdata), .cfg_we(cfg_we),
    .cfg_wrap_x(cfg_wrap_x), .cfg_wrap_y(cfg_wrap_y),
    .x_go(x_go), .x_sel(x_sel), .x_mode(x_mode),
    .y_go(y_go), .y_sel(y_sel), .y_mode(y_mode),
    .x_addr(x_addr), .x_next(x_next), .x_valid(x_valid),
    .y_addr(y_addr), .y_next(y_next), .y_valid(y_valid));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input bit side, input logic [1:0] tgt, input logic [PW-1:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = {side, tgt}; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic wr_mod(input logic [LW-1:0] me, input logic [LW-1:0] ms);
    @(negedge clk);
    mod_we = 1; mod_wdata = {me, ms};
    @(negedge clk);
    mod_we = 0;
  endtask

  task automatic wr_cfg(input bit ex, input bit ey);
    @(negedge clk);
    cfg_we = 1; cfg_wrap_x = ex; cfg_wrap_y = ey;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic xfer(input bit xg, input bit xs, input logic [1:0] xm,
                      input bit yg, input bit ys, input logic [1:0] ym);
    @(negedge clk);
    x_go = xg; x_sel = xs; x_mode = xm; y_go = yg; y_sel = ys; y_mode = ym;
    @(negedge clk);
    x_go = 0; y_go = 0;
  endtask

  function automatic logic [PW-1:0] model(input logic [PW-1:0] cur, input logic [1:0] mode,
      input logic [PW-1:0] idx, input bit en, input logic [LW-1:0] ms, input logic [LW-1:0] me);
    bit upd = (mode == 2'd1) || (mode == 2'd2);
    if (en && upd && cur[LW-1:1] == me[LW-1:1])
      return {cur[PW-1:LW], ms[LW-1:1], 1'b0};
    if (mode == 2'd1) return cur + PW'(2);
    if (mode == 2'd2) return cur + idx;
    return cur;
  endfunction

  localparam logic [LW-1:0] ME0 = 8'h35;
  localparam logic [LW-1:0] MS0 = 8'h11;
  localparam logic [PW-1:0] IDX = 12'h31C;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 x_valid", x_valid, 0); chk("R1 x_addr", x_addr, 0); chk("R1 x_next", x_next, 0);
    chk("R1 y_valid", y_valid, 0); chk("R1 y_addr", y_addr, 0); chk("R1 y_next", y_next, 0);
    xfer(1, 1, 2'd2, 1, 0, 2'd2);
    chk("R1 x ptr1+idx", x_next, 0); chk("R1 y ptr0+idx", y_next, 0);
    xfer(1, 0, 2'd1, 1, 1, 2'd1);
    chk("R1 x no wrap at reset", x_next, 2); chk("R1 y no wrap at reset", y_next, 2);

    // R2 / R4 directed loads and write-back
    wr_reg(0, 2'd1, 12'h3F0);
    wr_reg(0, 2'd2, 12'h004);
    wr_reg(1, 2'd0, 12'h155);
    wr_reg(1, 2'd3, 12'hFFF);
    xfer(1, 1, 2'd2, 0, 0, 2'd0);
    chk("R3 x addr", x_addr, 12'h0F0 >> 1); chk("R4 x index add", x_next, 12'h3F4);
    chk("R12 y idle", y_valid, 0);
    xfer(1, 1, 2'd0, 0, 0, 2'd0);
    chk("R4 x writeback", x_next, 12'h3F4);
    xfer(1, 0, 2'd0, 1, 0, 2'd0);
    chk("R2 x ptr0 untouched", x_next, 12'h002);
    chk("R2 y ptr0 loaded", y_next, 12'h155);
    xfer(0, 0, 2'd0, 1, 1, 2'd2);
    chk("R2 y idx untouched by target 3", y_next, 12'h002);
    chk("R12 x idle", x_valid, 0);
    // R11 carry into upper bits
    wr_reg(0, 2'd0, 12'h0FE);
    xfer(1, 0, 2'd1, 0, 0, 2'd0);
    chk("R11 carry", x_next, 12'h100);

    // R9 modulo load; bit 0 of both fields set to show R8
    wr_mod(ME0, MS0);
    wr_reg(0, 2'd2, IDX);
    wr_reg(1, 2'd2, IDX);
    for (int side = 0; side < 2; side++) begin
      for (int en = 0; en < 2; en++) begin
        wr_cfg(side == 0 ? en[0] : !en[0], side == 1 ? en[0] : !en[0]);
        for (int mode = 0; mode < 4; mode++) begin
          for (int low = 0; low < 256; low++) begin
            logic [PW-1:0] cur, exp;
            bit sel, match, upd;
            string tag;
            cur = {4'(low) ^ 4'h9, 8'(low)};
            sel = low[0];
            wr_reg(side[0], {1'b0, sel}, cur);
            if (side == 0) xfer(1, sel, 2'(mode), 0, 0, 2'd0);
            else           xfer(0, 0, 2'd0, 1, sel, 2'(mode));
            exp = model(cur, 2'(mode), IDX, en[0], MS0, ME0);
            match = cur[LW-1:1] == ME0[LW-1:1];
            upd = (mode == 1) || (mode == 2);
            if (match && upd && en == 1) tag = "R5 wrap (R8 bit0 ignored)";
            else if (match && !upd)      tag = "R6 no wrap without update";
            else if (match)              tag = "R7 wrap disabled";
            else                         tag = "R4 update";
            if (side == 0) begin
              chk("R3 x valid", x_valid, 1);
              chk("R3 x addr", x_addr, cur[LW-1:1]);
              chk(tag, x_next, exp);
            end else begin
              chk("R3 y valid", y_valid, 1);
              chk("R3 y addr", y_addr, cur[LW-1:1]);
              chk(tag, y_next, exp);
            end
          end
        end
      end
    end

    // R10 both sides wrap in the same cycle against one pair
    wr_cfg(1, 1);
    wr_reg(0, 2'd0, 12'h235);
    wr_reg(1, 2'd1, 12'h734);
    xfer(1, 0, 2'd1, 1, 1, 2'd2);
    chk("R10 x wrap", x_next, 12'h210); chk("R10 y wrap", y_next, 12'h710);
    // R7 enables apply per side
    wr_cfg(1, 0);
    wr_reg(0, 2'd0, 12'h235);
    wr_reg(1, 2'd1, 12'h734);
    xfer(1, 0, 2'd1, 1, 1, 2'd1);
    chk("R7 x enabled", x_next, 12'h210); chk("R7 y disabled", y_next, 12'h736);
    wr_cfg(0, 1);
    wr_reg(0, 2'd0, 12'h235);
    wr_reg(1, 2'd1, 12'h734);
    xfer(1, 0, 2'd1, 1, 1, 2'd1);
    chk("R7 x disabled", x_next, 12'h237); chk("R7 y enabled", y_next, 12'h710);
    // R9 reload of modulo register, R8 start bit 0 dropped
    wr_mod(8'h80, 8'h41);
    wr_cfg(1, 1);
    wr_reg(0, 2'd0, 12'hC81);
    xfer(1, 0, 2'd1, 0, 0, 2'd0);
    chk("R9 new pair wrap", x_next, 12'hC40);
    xfer(1, 0, 2'd1, 0, 0, 2'd0);
    chk("R9 after wrap", x_next, 12'hC42);
    @(negedge clk);
    chk("R12 idle after transfer", x_valid, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule